// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block burns one word of a one-time-programmable fuse array. On a start request it latches the target word address and the requested data. It then reads the word currently held in the fuses and removes every bit that is already blown from the data. What remains is walked out one bit at a time, lowest position first. Each position that still holds a 1 gets a program pulse, and each position that holds a 0 is stepped over.

All pulse and spacing lengths come from a timing configuration word, counted in clock cycles. After the last bit the block drops busy and pulses done. It then holds a fixed quiet window before it requests a shadow reload. A start that arrives inside the quiet window is kept and begins when the window closes, so it is not lost. A start that arrives while the block is busy is ignored.

The fuse array itself lives outside the block. The block only drives an address, a bit index, a program strobe and a read strobe, and it takes back the full word on a read data bus.

Top module: `fuse_prog_seq`

## Requirements
- R1: During and right after reset, busy, done, reload_req, fuse_prog and fuse_rd are all low.
- R2: timing_cfg fields: program base length in bits [11:0], spacing length S in bits [15:12], read base length in bits [21:16]. They are sampled in the cycle a start is accepted. The operation begins with S+1 busy cycles, followed by fuse_rd held for read_base+2*S+1 cycles.
- R3: Bits that the pre-read returns as 1 are never strobed. The number of fuse_prog pulses equals the count of ones in (data AND NOT old word), and afterwards the fuse word equals old OR data.
- R4: Bit positions are visited one at a time in strictly ascending order, from 0 up to the word width minus 1, and fuse_bit shows the current position.
- R5: Each fuse_prog pulse lasts exactly prog_base+2*S+1 cycles, and fuse_bit is constant during the pulse.
- R6: Every bit position, programmed or not, is preceded by S+1 spacing cycles. busy is therefore high for (S+1)*(W+1) + (read_base+2*S+1) + n*(prog_base+2*S+1) cycles, where W is the word width and n is the pulse count.
- R7: done is a single-cycle pulse in the first cycle with busy low. reload_req is a single-cycle pulse exactly QUIET_CYCLES cycles later.
- R8: A start while busy is high has no effect: no fuse of its address changes, and no operation follows.
- R9: The first start seen during the quiet window is held and launches in the cycle reload_req is high, so busy is high in that cycle too. Later starts in the same window are ignored.
- R10: fuse_prog and fuse_rd are never high together, and fuse_addr stays equal to the accepted address while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to program one word |
| start_addr | input | ADDR_W | Target word address |
| start_data | input | WORD_W | Bits to program (1 = blow) |
| timing_cfg | input | 22 | Program, spacing and read lengths |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-programming pulse |
| reload_req | output | 1 | One-cycle shadow reload request after the quiet window |
| fuse_addr | output | ADDR_W | Word address to the fuse array |
| fuse_bit | output | log2(WORD_W) | Bit position being handled |
| fuse_prog | output | 1 | Program strobe |
| fuse_rd | output | 1 | Read strobe |
| fuse_rdata | input | WORD_W | Word returned by the fuse array |

## Verification
The closing of the quiet window can coincide with the launch of a held request. In that cycle the reload request is raised and the next operation's first setup cycle starts at the same edge. The bench provokes this by issuing two starts a few cycles into a quiet window. It then checks that busy is already high in the sample where reload_req is seen. It also checks that the first held word is programmed correctly and that the second request left its word untouched.

// File: rtl/fuse_prog_pkg.sv
// Shared constants and types for the fuse word programming sequencer.
// Assumes the timing configuration layout is fixed by the fuse macro.
package fuse_prog_pkg;
    localparam int PROG_W    = 12;
    localparam int RELAX_W   = 4;
    localparam int READ_W    = 6;
    localparam int PROG_LSB  = 0;
    localparam int RELAX_LSB = 12;
    localparam int READ_LSB  = 16;
    localparam int TIME_W    = READ_LSB + READ_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SETUP,
        S_RD_STROBE,
        S_BIT_SETUP,
        S_BIT_STROBE,
        S_QUIET
    } seq_state_e;

    typedef struct packed {
        logic [READ_W-1:0]  rd;
        logic [RELAX_W-1:0] relax;
        logic [PROG_W-1:0]  prog;
    } tfield_t;

    function automatic tfield_t split_timing(input logic [TIME_W-1:0] w);
        tfield_t t;
        t.prog  = w[PROG_LSB  +: PROG_W];
        t.relax = w[RELAX_LSB +: RELAX_W];
        t.rd    = w[READ_LSB  +: READ_W];
        return t;
    endfunction
endpackage

// File: rtl/fuse_prog_timing.sv
// Turns the timing configuration into phase lengths, each stored as
// length minus one. Captured at operation start so a later change
// of the input cannot disturb a running sequence.
module fuse_prog_timing
    import fuse_prog_pkg::*;
#(
    parameter int CNT_W = PROG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] timing_cfg,
    output logic [CNT_W-1:0]  setup_now,
    output logic [CNT_W-1:0]  setup_len,
    output logic [CNT_W-1:0]  strobe_len,
    output logic [CNT_W-1:0]  read_len
);
    tfield_t tf;

    // Decode the live configuration word.
    always_comb tf = split_timing(timing_cfg);

    // First setup phase uses the live value, since it begins at the load edge.
    always_comb setup_now = CNT_W'(tf.relax);

    // Hold the per-operation lengths; both strobes carry 2*S+1 extra cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_len  <= '0;
            strobe_len <= '0;
            read_len   <= '0;
        end else if (load) begin
            setup_len  <= CNT_W'(tf.relax);
            strobe_len <= CNT_W'(tf.prog) + (CNT_W'(tf.relax) << 1);
            read_len   <= CNT_W'(tf.rd)   + (CNT_W'(tf.relax) << 1);
        end
    end

    p_len_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(strobe_len) && $stable(read_len));
endmodule

// File: rtl/fuse_prog_timer.sv
// Down counter for one sequencer phase. A phase loaded with N lasts
// N+1 cycles; expired is high in its last cycle.
module fuse_prog_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load at a phase change, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_prog_shifter.sv
// Holds the word to program. The word is masked by the pre-read value,
// then shifted right with zero fill as each position finishes.
module fuse_prog_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] wdata,
    input  logic              capture,
    input  logic [WORD_W-1:0] rdata,
    input  logic              shift,
    output logic              cur_bit
);
    logic [WORD_W-1:0] dreg;

    // Latch, mask with the blown bits, then serialise from the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)       dreg <= '0;
        else if (accept)  dreg <= wdata;
        else if (capture) dreg <= dreg & ~rdata;
        else if (shift)   dreg <= {1'b0, dreg[WORD_W-1:1]};
    end

    assign cur_bit = dreg[0];

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (dreg & $past(rdata)) == '0);
endmodule

// File: rtl/fuse_prog_quiet.sv
// Post-write quiet window of QUIET_CYCLES cycles. last is high in the
// final cycle of the window. Assumes QUIET_CYCLES >= 1.
module fuse_prog_quiet #(
    parameter int QUIET_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic active,
    output logic last
);
    localparam int QW = $clog2(QUIET_CYCLES + 1);

    logic [QW-1:0] cnt;

    // Run the window once per arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (arm) begin
            active <= 1'b1;
            cnt    <= QW'(QUIET_CYCLES - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign last = active && (cnt == '0);

    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active && !last |=> active);
endmodule

// File: rtl/fuse_prog_seq.sv
// Top of the fuse word programming sequencer. Sequence: setup, pre-read,
// then per bit setup plus optional strobe, then quiet window, then reload
// request. Assumes the fuse array returns the word while fuse_rd is high.
module fuse_prog_seq
    import fuse_prog_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WORD_W       = 32,
    parameter int QUIET_CYCLES = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic [WORD_W-1:0]         start_data,
    input  logic [TIME_W-1:0]         timing_cfg,
    output logic                      busy,
    output logic                      done,
    output logic                      reload_req,
    output logic [ADDR_W-1:0]         fuse_addr,
    output logic [$clog2(WORD_W)-1:0] fuse_bit,
    output logic                      fuse_prog,
    output logic                      fuse_rd,
    input  logic [WORD_W-1:0]         fuse_rdata
);
    localparam int               BIT_W    = $clog2(WORD_W);
    localparam int               CNT_W    = PROG_W + 2;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_e        state, state_n;
    logic [BIT_W-1:0]  bit_idx;
    logic [ADDR_W-1:0] addr_q;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_data;

    logic              launch, quiet_last, quiet_on;
    logic [ADDR_W-1:0] launch_addr;
    logic [WORD_W-1:0] launch_data;
    logic [CNT_W-1:0]  setup_now, setup_len, strobe_len, read_len, tmr_val;
    logic              tmr_load, tmr_expired, cur_bit;
    logic              do_capture, do_shift, idx_clr, idx_inc, q_arm, bit_end;

    // A start is taken in idle, or when the quiet window closes (held one first).
    always_comb begin
        launch      = (state == S_IDLE && start) || (quiet_last && (start || pend_valid));
        launch_addr = pend_valid ? pend_addr : start_addr;
        launch_data = pend_valid ? pend_data : start_data;
    end

    fuse_prog_timing #(.CNT_W(CNT_W)) timing_i (
        .clk(clk), .rst_n(rst_n), .load(launch), .timing_cfg(timing_cfg),
        .setup_now(setup_now), .setup_len(setup_len),
        .strobe_len(strobe_len), .read_len(read_len)
    );

    fuse_prog_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    fuse_prog_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .accept(launch), .wdata(launch_data),
        .capture(do_capture), .rdata(fuse_rdata), .shift(do_shift),
        .cur_bit(cur_bit)
    );

    fuse_prog_quiet #(.QUIET_CYCLES(QUIET_CYCLES)) quiet_i (
        .clk(clk), .rst_n(rst_n), .arm(q_arm), .active(quiet_on), .last(quiet_last)
    );

    // Next state and phase-length selection.
    always_comb begin
        state_n    = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        do_capture = 1'b0;
        do_shift   = 1'b0;
        idx_clr    = 1'b0;
        idx_inc    = 1'b0;
        q_arm      = 1'b0;
        bit_end    = 1'b0;
        unique case (state)
            S_IDLE: if (launch) begin
                state_n = S_RD_SETUP; tmr_load = 1'b1; tmr_val = setup_now;
            end
            S_RD_SETUP: if (tmr_expired) begin
                state_n = S_RD_STROBE; tmr_load = 1'b1; tmr_val = read_len;
            end
            S_RD_STROBE: if (tmr_expired) begin
                state_n = S_BIT_SETUP; tmr_load = 1'b1; tmr_val = setup_len;
                do_capture = 1'b1; idx_clr = 1'b1;
            end
            S_BIT_SETUP: if (tmr_expired) begin
                if (cur_bit) begin
                    state_n = S_BIT_STROBE; tmr_load = 1'b1; tmr_val = strobe_len;
                end else begin
                    bit_end = 1'b1;
                end
            end
            S_BIT_STROBE: if (tmr_expired) bit_end = 1'b1;
            S_QUIET: if (quiet_last) begin
                if (launch) begin
                    state_n = S_RD_SETUP; tmr_load = 1'b1; tmr_val = setup_now;
                end else begin
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
        if (bit_end) begin
            do_shift = 1'b1;
            if (bit_idx == LAST_BIT) begin
                state_n = S_QUIET; q_arm = 1'b1;
            end else begin
                state_n = S_BIT_SETUP; tmr_load = 1'b1; tmr_val = setup_len;
                idx_inc = 1'b1;
            end
        end
    end

    // State, bit position, target address and end-of-operation pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            bit_idx    <= '0;
            addr_q     <= '0;
            done       <= 1'b0;
            reload_req <= 1'b0;
        end else begin
            state      <= state_n;
            done       <= q_arm;
            reload_req <= quiet_last;
            if (launch)       addr_q  <= launch_addr;
            if (idx_clr)      bit_idx <= '0;
            else if (idx_inc) bit_idx <= bit_idx + 1'b1;
        end
    end

    // Hold the first start seen during the quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (launch) begin
            pend_valid <= 1'b0;
        end else if (state == S_QUIET && start && !pend_valid) begin
            pend_valid <= 1'b1;
            pend_addr  <= start_addr;
            pend_data  <= start_data;
        end
    end

    assign busy      = (state == S_RD_SETUP) || (state == S_RD_STROBE) ||
                       (state == S_BIT_SETUP) || (state == S_BIT_STROBE);
    assign fuse_prog = (state == S_BIT_STROBE);
    assign fuse_rd   = (state == S_RD_STROBE);
    assign fuse_addr = addr_q;
    assign fuse_bit  = bit_idx;

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_prog && fuse_rd));
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(fuse_addr));
    p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_prog && !tmr_expired |=> fuse_prog && $stable(fuse_bit));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_reload_after_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |-> $past(quiet_on));
    p_no_pend_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE |-> !pend_valid);
    p_quiet_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_on |-> !busy);
endmodule

// File: tb/fuse_prog_seq_tb_top.sv
module fuse_prog_seq_tb_top;
    localparam int AW = 3;
    localparam int WW = 32;
    localparam int Q  = 20;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [WW-1:0] start_data = '0;
    logic [21:0]   timing_cfg = '0;
    logic          busy, done, reload_req, fuse_prog, fuse_rd;
    logic [AW-1:0] fuse_addr;
    logic [BW-1:0] fuse_bit;
    logic [WW-1:0] fuse_rdata;

    logic [WW-1:0] burned [8];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int exp_prog = 1;
    int exp_addr = 0;

    int busy_cnt, pre_rd, rd_w, strobes, rep_err, order_err, width_err, cur_w, last_bit;
    int done_cnt, reload_cnt, qc, q_meas, excl_err, addr_err;
    bit rd_seen, prev_prog, prev_busy, q_armed;
    logic [WW-1:0] mon_w;

    always #5 clk = ~clk;

    fuse_prog_seq #(.ADDR_W(AW), .WORD_W(WW), .QUIET_CYCLES(Q)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_data(start_data), .timing_cfg(timing_cfg), .busy(busy), .done(done),
        .reload_req(reload_req), .fuse_addr(fuse_addr), .fuse_bit(fuse_bit),
        .fuse_prog(fuse_prog), .fuse_rd(fuse_rd), .fuse_rdata(fuse_rdata)
    );

    function automatic logic [WW-1:0] init_word(input logic [AW-1:0] a);
        case (a)
            3'd2:    return 32'h0F0F_00FF;
            3'd7:    return 32'h0000_0003;
            default: return '0;
        endcase
    endfunction

    function logic [WW-1:0] fword(input logic [AW-1:0] a);
        return init_word(a) | burned[a];
    endfunction

    assign fuse_rdata = fuse_rd ? (init_word(fuse_addr) | burned[fuse_addr]) : '0;

    // Fuse model and protocol monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) burned[i] = '0;
            prev_prog = 0; prev_busy = 0; q_armed = 0;
        end else begin
            if (q_armed) begin
                qc++;
                if (reload_req) begin q_meas = qc; q_armed = 0; end
            end
            if (done) begin done_cnt++; q_armed = 1; qc = 0; end
            if (reload_req) reload_cnt++;
            if (busy && !prev_busy) begin
                busy_cnt = 0; pre_rd = 0; rd_w = 0; rd_seen = 0; strobes = 0;
                rep_err = 0; order_err = 0; width_err = 0; cur_w = 0; last_bit = -1;
                done_cnt = 0; reload_cnt = 0; q_meas = -1; excl_err = 0; addr_err = 0;
            end
            if (busy) busy_cnt++;
            if (busy && !fuse_rd && !rd_seen) pre_rd++;
            if (fuse_rd) begin rd_seen = 1; rd_w++; end
            if (busy && int'(fuse_addr) != exp_addr) addr_err++;
            if (fuse_prog && fuse_rd) excl_err++;
            if (fuse_prog) begin
                if (!prev_prog) begin
                    strobes++;
                    if (int'(fuse_bit) <= last_bit) order_err++;
                    last_bit = int'(fuse_bit);
                    mon_w = fword(fuse_addr);
                    if (mon_w[fuse_bit]) rep_err++;
                    burned[fuse_addr][fuse_bit] = 1'b1;
                    cur_w = 1;
                end else begin
                    cur_w++;
                    if (int'(fuse_bit) != last_bit) width_err++;
                end
            end else if (prev_prog && cur_w != exp_prog) begin
                width_err++;
            end
            prev_prog = fuse_prog;
            prev_busy = busy;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_timing(input int p, input int r, input int rd);
        timing_cfg = {rd[5:0], r[3:0], p[11:0]};
        exp_prog   = p + 2 * r + 1;
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [WW-1:0] d);
        @(negedge clk);
        start = 1'b1; start_addr = a; start_data = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic wait_reload();
        while (!reload_req) @(negedge clk);
    endtask

    task automatic check_op(input logic [AW-1:0] a, input logic [WW-1:0] old,
                            input logic [WW-1:0] d, input int p, input int r, input int rd);
        int n = 0;
        logic [WW-1:0] todo = d & ~old;
        for (int i = 0; i < WW; i++) if (todo[i]) n++;
        chk(pre_rd == r + 1, "R2 setup before read", pre_rd, r + 1);
        chk(rd_w == rd + 2 * r + 1, "R2 read strobe width", rd_w, rd + 2 * r + 1);
        chk(strobes == n, "R3 strobe count", strobes, n);
        chk(fword(a) == (old | d), "R3 fuse word", fword(a), old | d);
        chk(rep_err == 0, "R3 strobe on blown bit", rep_err, 0);
        chk(order_err == 0, "R4 ascending order", order_err, 0);
        chk(width_err == 0, "R5 program strobe width", width_err, 0);
        chk(busy_cnt == (r + 1) * (WW + 1) + rd + 2 * r + 1 + n * (p + 2 * r + 1),
            "R6 busy length", busy_cnt,
            (r + 1) * (WW + 1) + rd + 2 * r + 1 + n * (p + 2 * r + 1));
        chk(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        chk(reload_cnt == 1, "R7 reload pulses", reload_cnt, 1);
        chk(q_meas == Q, "R7 quiet window", q_meas, Q);
        chk(excl_err == 0, "R10 strobe exclusion", excl_err, 0);
        chk(addr_err == 0, "R10 address hold", addr_err, 0);
    endtask

    task automatic do_op(input logic [AW-1:0] a, input logic [WW-1:0] d,
                         input int p, input int r, input int rd);
        logic [WW-1:0] old = fword(a);
        set_timing(p, r, rd);
        exp_addr = int'(a);
        issue(a, d);
        wait_done();
        chk(!busy, "R7 busy low with done", busy, 0);
        wait_reload();
        @(negedge clk);
        #1;
        check_op(a, old, d, p, r, rd);
    endtask

    initial begin
        logic [WW-1:0] old_a, old_b, old_c, old_x;
        int seen_busy;
        repeat (5) @(negedge clk);
        chk({busy, done, reload_req, fuse_prog, fuse_rd} == 5'b0, "R1 in reset",
            {busy, done, reload_req, fuse_prog, fuse_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, reload_req, fuse_prog, fuse_rd} == 5'b0, "R1 after reset",
            {busy, done, reload_req, fuse_prog, fuse_rd}, 0);

        // R3 R4 R5 R6: assorted patterns and timings
        do_op(3'd0, 32'hA5A5_0001, 3, 0, 1);
        do_op(3'd1, 32'hFFFF_FFFF, 2, 1, 0);
        do_op(3'd2, 32'hFFFF_0F00, 5, 3, 7);
        do_op(3'd1, 32'hFFFF_FFFF, 1, 2, 2);
        do_op(3'd3, 32'h0000_0000, 0, 15, 63);
        do_op(3'd4, 32'h8000_0000, 4095, 0, 0);
        // R2 R6: sweep of the spacing length over disjoint bit sets
        for (int r = 0; r < 8; r++) do_op(3'd5, 32'h0101_0101 << r, r + 1, r, r);

        // R8: start while busy is ignored
        old_a = fword(3'd6); old_x = fword(3'd7);
        set_timing(2, 1, 3); exp_addr = 6;
        issue(3'd6, 32'h00FF_00FF);
        repeat (6) @(negedge clk);
        chk(busy, "R8 still busy at second start", busy, 1);
        issue(3'd7, 32'hFFFF_0000);
        wait_done();
        wait_reload();
        @(negedge clk);
        #1;
        check_op(3'd6, old_a, 32'h00FF_00FF, 2, 1, 3);
        seen_busy = 0;
        for (int i = 0; i < 2 * Q; i++) begin
            @(negedge clk);
            if (busy) seen_busy++;
        end
        chk(seen_busy == 0, "R8 no operation after ignored start", seen_busy, 0);
        chk(fword(3'd7) == old_x, "R8 word untouched", fword(3'd7), old_x);

        // R9: held start during quiet launches with the reload request
        old_a = fword(3'd0); old_b = fword(3'd3); old_c = fword(3'd4);
        set_timing(1, 1, 1); exp_addr = 0;
        issue(3'd0, 32'h0000_0F00);
        wait_done();
        chk(fword(3'd0) == (old_a | 32'h0000_0F00), "R9 first word", fword(3'd0),
            old_a | 32'h0000_0F00);
        exp_addr = 3;
        @(negedge clk);
        issue(3'd3, 32'h1234_5678);
        @(negedge clk);
        issue(3'd4, 32'hFFFF_FFFF);
        wait_reload();
        chk(busy, "R9 launch in reload cycle", busy, 1);
        @(negedge clk);
        wait_done();
        wait_reload();
        @(negedge clk);
        #1;
        check_op(3'd3, old_b, 32'h1234_5678, 1, 1, 1);
        chk(fword(3'd4) == old_c, "R9 later start ignored", fword(3'd4), old_c);

        summary();
        $finish;
    end
endmodule